// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block drives the read/write strobe of one programmed-I/O transfer on an IDE channel behind a local-bus host. Software loads timing bytes into a small bank of timer registers. When a transfer request is accepted, the block picks one timer from the variant input, the channel-routing input and the drive addressed by the request. It decodes that byte into an active count and a recovery count, both in bus clocks. It then holds the strobe high for the active count and stays busy for the recovery count before it reports completion.

Both counts are kept in complemented form: each is a fixed base minus the field in the timing byte. The base depends on the decode variant: a dual-channel style, or a single-channel style that also looks at a bus-speed strap. Decoded counts outside the legal window are clamped to its nearest edge. A timing byte is read only at the moment a request is accepted, so a register write never changes a cycle that is already in progress.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, req_ready is 1, strobe and done are 0, and every timer holds 8'h1B. In the single-channel variant with slow_bus=1 this gives 6 active clocks and 14 recovery clocks.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. strobe is 1 for exactly the active count of cycles, starting in the cycle after acceptance. req_ready is 0 from acceptance until the done cycle.
- R3: Recovery takes exactly the recovery count of cycles, starting in the cycle after strobe falls, with strobe 0 and req_ready 0. done is then 1 for one cycle, in which req_ready is already 1. With a recovery count of 0, the done cycle directly follows the last strobe cycle.
- R4: Dual-channel variant (dual_mode=1): the active count is 17 minus bits 3:0 and the recovery count is 15 minus bits 7:4. slow_bus has no effect.
- R5: In the dual-channel variant, a recovery count that would fall below 2 (bits 7:4 equal to 14 or 15) is clamped to 2.
- R6: Single-channel variant with slow_bus=1: the active count is 9 minus bits 2:0 and the recovery count is 15 minus bits 7:4, so a recovery of 0 is legal.
- R7: Single-channel variant with slow_bus=0: the active count is 8 minus bits 2:0 and the recovery count is 18 minus bits 7:4.
- R8: A write made while dual_mode=0 stores the byte with bit 3 forced to 1. The forced bit is visible when the dual-channel variant later decodes that timer.
- R9: The timer is selected at acceptance. In the single-channel variant it is always timer 0. In the dual-channel variant with primary_only=1 it is the timer numbered req_dev. With primary_only=0 it is the timer numbered req_chan.
- R10: A timer write made during a transfer leaves that transfer's counts unchanged and applies from the next accepted request.
- R11: req_valid, req_chan and req_dev have no effect while req_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 selects the dual-channel decode, 0 the single-channel decode |
| slow_bus | input | 1 | Bus-speed strap: 1 means 33 MHz or less |
| primary_only | input | 1 | Dual-channel routing: 1 gives each drive its own timer |
| wr_en | input | 1 | Timer write strobe |
| wr_sel | input | SEL_W | Index of the timer to write |
| wr_data | input | 8 | Timing byte: active field in bits 3:0, recovery field in bits 7:4 |
| req_valid | input | 1 | Transfer request |
| req_chan | input | 1 | Channel of the request |
| req_dev | input | 1 | Drive of the request (0 master, 1 slave) |
| req_ready | output | 1 | Block can accept a request this cycle |
| strobe | output | 1 | Read/write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the strobe width and the recovery gap at the decode extremes: an active count of 1, a recovery count of 0, and a recovery field of 14 that falls below the dual-channel minimum. A design that added or dropped a count, or that failed to clamp, would show a strobe or gap one cycle off, or a recovery that wraps to a very long wait. Timer writes that hit a busy cycle, requests held high while busy, and a byte written in single-channel mode and then read in dual-channel mode expose a design that reads its timer live, that accepts requests while busy, or that stores the byte without forcing bit 3. The routing cases select one timer per variant, so a swapped channel and drive select shows up as the other timer's counts.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    localparam int TIMING_W = 8;
    localparam int CNT_W    = 5;

    // bit forced high by single-channel writes
    localparam int SINGLE_FLAG_BIT = 3;

    // complemented-count bases and legal windows
    localparam int DUAL_ACT_BASE = 17;
    localparam int DUAL_ACT_MIN  = 2;
    localparam int DUAL_ACT_MAX  = 17;
    localparam int DUAL_REC_BASE = 15;
    localparam int DUAL_REC_MIN  = 2;
    localparam int DUAL_REC_MAX  = 15;

    localparam int SLOW_ACT_BASE = 9;
    localparam int SLOW_ACT_MIN  = 2;
    localparam int SLOW_ACT_MAX  = 9;
    localparam int SLOW_REC_BASE = 15;
    localparam int SLOW_REC_MIN  = 0;
    localparam int SLOW_REC_MAX  = 15;

    localparam int FAST_ACT_BASE = 8;
    localparam int FAST_ACT_MIN  = 1;
    localparam int FAST_ACT_MAX  = 8;
    localparam int FAST_REC_BASE = 18;
    localparam int FAST_REC_MIN  = 3;
    localparam int FAST_REC_MAX  = 18;

    typedef logic [TIMING_W-1:0] timing_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        cnt_t   cnt;
        cnt_t   rec;
        logic   done;
    } seq_state_t;

endpackage

// File: rtl/pio_timing_bank.sv
module pio_timing_bank
    import pio_strobe_pkg::*;
#(
    parameter int      N_TIMERS       = 2,
    parameter timing_t DEFAULT_TIMING = 8'h1B,
    localparam int     SEL_W          = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dual_mode,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  timing_t          wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output timing_t          rd_data
);

    timing_t tmr_d [N_TIMERS];
    timing_t tmr_q [N_TIMERS];
    timing_t wr_val;

    always_comb begin
        wr_val = wr_data;
        if (!dual_mode) begin
            wr_val[SINGLE_FLAG_BIT] = 1'b1;
        end
    end

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        assign tmr_d[i] = (wr_en && (wr_sel == SEL_W'(i))) ? wr_val : tmr_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TIMERS; i++) begin
                tmr_q[i] <= DEFAULT_TIMING;
            end
        end else begin
            for (int i = 0; i < N_TIMERS; i++) begin
                tmr_q[i] <= tmr_d[i];
            end
        end
    end

    always_comb begin
        rd_data = tmr_q[0];
        for (int i = 0; i < N_TIMERS; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = tmr_q[i];
            end
        end
    end

endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
    import pio_strobe_pkg::*;
(
    input  logic    dual_mode,
    input  logic    slow_bus,
    input  timing_t timing,
    output cnt_t    act_cnt,
    output cnt_t    rec_cnt
);

    function automatic cnt_t fold(input int base, input int field,
                                  input int lo, input int hi);
        int v;
        v = base - field;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return cnt_t'(v);
    endfunction

    int act_field_wide;
    int act_field_narrow;
    int rec_field;

    always_comb begin
        act_field_wide   = int'(timing[3:0]);
        act_field_narrow = int'(timing[2:0]);
        rec_field        = int'(timing[7:4]);
        if (dual_mode) begin
            act_cnt = fold(DUAL_ACT_BASE, act_field_wide, DUAL_ACT_MIN, DUAL_ACT_MAX);
            rec_cnt = fold(DUAL_REC_BASE, rec_field, DUAL_REC_MIN, DUAL_REC_MAX);
        end else if (slow_bus) begin
            act_cnt = fold(SLOW_ACT_BASE, act_field_narrow, SLOW_ACT_MIN, SLOW_ACT_MAX);
            rec_cnt = fold(SLOW_REC_BASE, rec_field, SLOW_REC_MIN, SLOW_REC_MAX);
        end else begin
            act_cnt = fold(FAST_ACT_BASE, act_field_narrow, FAST_ACT_MIN, FAST_ACT_MAX);
            rec_cnt = fold(FAST_REC_BASE, rec_field, FAST_REC_MIN, FAST_REC_MAX);
        end
    end

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_strobe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  cnt_t act_cnt,
    input  cnt_t rec_cnt,
    output logic ready,
    output logic strobe,
    output logic done
);

    seq_state_t s_d;
    seq_state_t s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_ACTIVE;
                    s_d.cnt   = act_cnt - cnt_t'(1);
                    s_d.rec   = rec_cnt;
                end
            end
            PH_ACTIVE: begin
                if (s_q.cnt == '0) begin
                    if (s_q.rec == '0) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_RECOVER;
                        s_d.cnt   = s_q.rec - cnt_t'(1);
                    end
                end else begin
                    s_d.cnt = s_q.cnt - cnt_t'(1);
                end
            end
            PH_RECOVER: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - cnt_t'(1);
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, rec: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready  = (s_q.phase == PH_IDLE);
    assign strobe = (s_q.phase == PH_ACTIVE);
    assign done   = s_q.done;

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_strobe_pkg::*;
#(
    parameter int      N_TIMERS       = 2,
    parameter timing_t DEFAULT_TIMING = 8'h1B,
    localparam int     SEL_W          = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dual_mode,
    input  logic             slow_bus,
    input  logic             primary_only,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             req_valid,
    input  logic             req_chan,
    input  logic             req_dev,
    output logic             req_ready,
    output logic             strobe,
    output logic             done
);

    logic [SEL_W-1:0] rd_sel;
    timing_t          cur_timing;
    cnt_t             act_cnt;
    cnt_t             rec_cnt;

    always_comb begin
        if (!dual_mode) begin
            rd_sel = '0;
        end else if (primary_only) begin
            rd_sel = SEL_W'(req_dev);
        end else begin
            rd_sel = SEL_W'(req_chan);
        end
    end

    pio_timing_bank #(
        .N_TIMERS       (N_TIMERS),
        .DEFAULT_TIMING (DEFAULT_TIMING)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual_mode (dual_mode),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (cur_timing)
    );

    pio_timing_decode i_decode (
        .dual_mode (dual_mode),
        .slow_bus  (slow_bus),
        .timing    (cur_timing),
        .act_cnt   (act_cnt),
        .rec_cnt   (rec_cnt)
    );

    pio_strobe_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (req_valid),
        .act_cnt (act_cnt),
        .rec_cnt (rec_cnt),
        .ready   (req_ready),
        .strobe  (strobe),
        .done    (done)
    );

endmodule

// File: rtl/pio_strobe_checker.sv
module pio_strobe_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic strobe,
    input logic done
);

    // R2: a strobe is only ever driven while the block is busy
    p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !req_ready);

    // R2: an accepted request raises the strobe on the next cycle
    p_accept_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> strobe);

    // R3: done lasts a single cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: the done cycle is already ready for a new request
    p_done_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R11: the strobe only rises after an accepted request
    p_rise_needs_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(req_valid && req_ready));

endmodule

bind pio_strobe_gen pio_strobe_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .strobe    (strobe),
    .done      (done)
);

// File: tb/test_pio_strobe_gen.sv
module test_pio_strobe_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dual_mode = 1'b0;
    logic       slow_bus = 1'b1;
    logic       primary_only = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       req_valid = 1'b0;
    logic       req_chan = 1'b0;
    logic       req_dev = 1'b0;
    logic       req_ready;
    logic       strobe;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pio_strobe_gen i_pio_strobe_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .dual_mode    (dual_mode),
        .slow_bus     (slow_bus),
        .primary_only (primary_only),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .req_valid    (req_valid),
        .req_chan     (req_chan),
        .req_dev      (req_dev),
        .req_ready    (req_ready),
        .strobe       (strobe),
        .done         (done)
    );

    // ---------------- behavioural reference ----------------
    int m_phase;
    int m_act;
    int m_rec;
    bit m_done;
    int m_tmr [2];

    function automatic void exp_counts(input bit dual, input bit slow, input int tb,
                                       output int a, output int r);
        int rf;
        rf = (tb >> 4) & 15;
        if (dual) begin
            a = 17 - (tb & 15);
            r = 15 - rf;
            if (a < 2) a = 2;
            if (r < 2) r = 2;
        end else if (slow) begin
            a = 9 - (tb & 7);
            r = 15 - rf;
        end else begin
            a = 8 - (tb & 7);
            r = 18 - rf;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase  = 0;
            m_done   = 0;
            m_act    = 0;
            m_rec    = 0;
            m_tmr[0] = 8'h1B;
            m_tmr[1] = 8'h1B;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    int s;
                    int a;
                    int r;
                    s = dual_mode ? (primary_only ? int'(req_dev) : int'(req_chan)) : 0;
                    exp_counts(dual_mode, slow_bus, m_tmr[s], a, r);
                    m_act   = a;
                    m_rec   = r;
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_act = m_act - 1;
                if (m_act == 0) begin
                    if (m_rec == 0) begin
                        m_phase = 0;
                        m_done  = 1;
                    end else begin
                        m_phase = 2;
                    end
                end
            end else begin
                m_rec = m_rec - 1;
                if (m_rec == 0) begin
                    m_phase = 0;
                    m_done  = 1;
                end
            end
            if (wr_en) begin
                m_tmr[int'(wr_sel)] = dual_mode ? int'(wr_data) : (int'(wr_data) | 8);
            end
        end
    end

    // per-cycle comparison against the reference (R2, R3)
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (strobe !== (m_phase == 1) || req_ready !== (m_phase == 0) ||
                done !== m_done) begin
                n_bad++;
                $display("FAIL R2 R3 per-cycle: strobe/ready/done actual %b%b%b expected %b%b%b",
                         strobe, req_ready, done, (m_phase == 1), (m_phase == 0), m_done);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_tmr(input bit sel, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_xfer(input bit ch, input bit dv, input int ea, input int er,
                            input string tag, input bit mid_wr, input bit mid_sel,
                            input logic [7:0] mid_data, input bit hold);
        int a;
        int r;
        int guard;
        a = 0;
        r = 0;
        guard = 0;
        req_chan  = ch;
        req_dev   = dv;
        req_valid = 1'b1;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        while (strobe === 1'b1 && guard < 200) begin
            a++;
            if (mid_wr && a == 1) begin
                wr_en   = 1'b1;
                wr_sel  = mid_sel;
                wr_data = mid_data;
            end else begin
                wr_en = 1'b0;
            end
            if (hold) begin
                req_chan = ~ch;
                req_dev  = ~dv;
            end
            @(negedge clk);
            guard++;
        end
        wr_en = 1'b0;
        while (done !== 1'b1 && guard < 200) begin
            r++;
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        req_chan  = ch;
        req_dev   = dv;
        check({tag, " active"}, a, ea);
        check({tag, " recovery"}, r, er);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected finish");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 strobe after reset", int'(strobe), 0);
        check("R1 done after reset", int'(done), 0);

        // single-channel, slow strap, default byte
        run_xfer(0, 0, 6, 14, "R1 R6 default slow", 0, 0, 8'h00, 0);
        slow_bus = 1'b0;
        run_xfer(0, 0, 5, 17, "R7 default fast", 0, 0, 8'h00, 0);

        slow_bus = 1'b1;
        write_tmr(0, 8'hF0);
        run_xfer(0, 0, 9, 0, "R6 zero recovery", 0, 0, 8'h00, 0);
        write_tmr(0, 8'h07);
        run_xfer(0, 0, 2, 15, "R6 short active", 0, 0, 8'h00, 0);

        slow_bus = 1'b0;
        run_xfer(0, 0, 1, 18, "R7 one-clock active", 0, 0, 8'h00, 0);
        write_tmr(0, 8'hF0);
        run_xfer(0, 0, 8, 3, "R7 long active", 0, 0, 8'h00, 0);

        // single-channel always uses timer 0
        write_tmr(1, 8'h07);
        run_xfer(1, 1, 8, 3, "R9 single uses timer0", 0, 0, 8'h00, 0);

        // dual-channel, drive routing
        dual_mode    = 1'b1;
        slow_bus     = 1'b1;
        primary_only = 1'b1;
        run_xfer(0, 1, 2, 15, "R4 R9 dual dev1 timer1", 0, 0, 8'h00, 0);
        run_xfer(0, 0, 9, 2, "R8 R5 dual forced bit3 clamp", 0, 0, 8'h00, 0);
        write_tmr(0, 8'h00);
        run_xfer(0, 0, 17, 15, "R4 dual max counts", 0, 0, 8'h00, 0);
        write_tmr(1, 8'hE5);
        run_xfer(1, 1, 12, 2, "R5 dual recovery clamp", 0, 0, 8'h00, 0);

        // dual-channel, channel routing
        primary_only = 1'b0;
        run_xfer(0, 1, 17, 15, "R9 chan0 timer0", 0, 0, 8'h00, 0);
        run_xfer(1, 0, 12, 2, "R9 chan1 timer1", 0, 0, 8'h00, 0);

        // write in the middle of a transfer
        run_xfer(0, 0, 17, 15, "R10 mid-write current", 1, 0, 8'h88, 0);
        run_xfer(0, 0, 9, 7, "R10 mid-write next", 0, 0, 8'h00, 0);

        // requests held while busy
        run_xfer(1, 0, 12, 2, "R11 held request", 0, 0, 8'h00, 1);
        @(negedge clk);
        check("R11 no extra transfer", int'(req_ready), 1);

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule